// File: doc/BRIEF.md
# Block Storage Controller Register Target

This block is the register slave of a DMA block-storage controller. A bus master sets up a transfer through a 32-byte window of eight 32-bit word registers. It programs the memory buffer address, the number of blocks and the first logical block index, and then writes an opcode. The transfer engine runs outside this block. The block sends the engine a one-cycle start pulse with the opcode, presents the stored parameters to it, and reads back the engine's 3-bit status code.

When the engine reaches a terminal state (a read or write that succeeded or failed), the block raises its interrupt if the interrupt enable is set. A status read in a terminal state sends an acknowledge pulse to the engine. The engine then returns to idle, which also drops the interrupt. While the engine is not idle, writes to the parameter and opcode registers are accepted on the bus but have no effect.

The bus side is a single-beat request/response port. Every request gets a response exactly one cycle later, and that response carries the requester's identifiers. Illegal accesses get an error response and change nothing.

Top module: `blkctl_target`

## Requirements
- R1: After reset the buffer address, block count and block index read as 0, the interrupt enable reads as 1, and rsp_valid, eng_start and eng_ack are low.
- R2: While eng_status is 0 (idle), a write to offset 0x00 (buffer address), 0x04 (block count) or 0x08 (first block index) stores the full 32-bit value, and a read of that offset returns it.
- R3: While eng_status is not 0, writes to offsets 0x00, 0x04, 0x08 and 0x0C get a non-error response and change neither a stored value nor eng_start.
- R4: While idle, a write of exactly 1 (read) or 2 (write) to offset 0x0C raises eng_start for one cycle, in the response cycle, with eng_op equal to that value. Any other value, including 0 (no-op), raises no start.
- R5: A read of offset 0x10 returns eng_status, as sampled in the request cycle, in bits 2:0, with all upper bits zero. Codes: 0 idle, 1 busy, 2 read ok, 3 write ok, 4 read error, 5 write error.
- R6: A status read while eng_status is 2, 3, 4 or 5 raises eng_ack for one cycle, in the response cycle. No other access raises eng_ack.
- R7: irq is high exactly when eng_status is in 2..5 and the interrupt enable is set.
- R8: A write to offset 0x14 sets the interrupt enable to 1 if the data is non-zero and to 0 otherwise, in any engine state. A read of 0x14 returns 0 or 1.
- R9: A read of offset 0x18 returns DEV_BLOCKS, and a read of offset 0x1C returns BLOCK_BYTES.
- R10: The following accesses get rsp_error=1 and rsp_rdata=0, and change no stored value: a read of 0x0C; a write to 0x10, 0x18 or 0x1C; an address with bits 1:0 non-zero; an address at or above 0x20.
- R11: Every accepted request (req_valid high at a clock edge) produces rsp_valid in the next cycle only, with rsp_srcid, rsp_trdid and rsp_pktid equal to the request's values.
- R12: cfg_buf_addr, cfg_count and cfg_lba always show the stored buffer address, block count and block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address within the target's space |
| req_wdata | input | 32 | Write data |
| req_srcid | input | SRCID_W | Requester source identifier |
| req_trdid | input | TRDID_W | Requester transaction identifier |
| req_pktid | input | PKTID_W | Requester packet identifier |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_error | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| rsp_srcid | output | SRCID_W | Echoed source identifier |
| rsp_trdid | output | TRDID_W | Echoed transaction identifier |
| rsp_pktid | output | PKTID_W | Echoed packet identifier |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 2 | Operation for the start: 1 read, 2 write |
| eng_status | input | 3 | Engine status code |
| eng_ack | output | 1 | Terminal-status acknowledge pulse |
| cfg_buf_addr | output | 32 | Stored memory buffer address |
| cfg_count | output | 32 | Stored block count |
| cfg_lba | output | 32 | Stored first block index |
| irq | output | 1 | Completion interrupt |

## Verification
Every one of the 256 local addresses is read with an idle engine, and every illegal write is swept as well. This separates legal decoding from each error class: misalignment, out-of-window, a write to a read-only register and a read of the write-only register. Each status code 0 to 7 is tried with a status read, with parameter and opcode writes, and with both interrupt-enable settings. This shows that the acknowledge, the interrupt and the write lockout each key on the right subset of codes. The opcode register is driven with 0, 1, 2, 3 and a value with upper bits set, which separates exact opcode matching from a match on the low bits only. Data patterns include all-ones and walking values, which catch truncated or swapped register storage.

// File: rtl/blkctl_pkg.sv
package blkctl_pkg;

    // Register index = word offset within the 32-byte window (offset order is decoded).
    typedef enum logic [2:0] {
        SEL_BUF   = 3'd0,
        SEL_CNT   = 3'd1,
        SEL_LBA   = 3'd2,
        SEL_OP    = 3'd3,
        SEL_STAT  = 3'd4,
        SEL_IRQEN = 3'd5,
        SEL_SIZE  = 3'd6,
        SEL_BSIZE = 3'd7
    } reg_sel_e;

    localparam logic [2:0] ST_IDLE = 3'd0;
    localparam logic [2:0] ST_BUSY = 3'd1;

    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    localparam int WORD_W   = 32;
    localparam int WIN_BITS = 5;

    function automatic logic is_terminal(input logic [2:0] s);
        return (s >= 3'd2) && (s <= 3'd5);
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] lba;
        logic              irq_en;
        logic              start;
        logic [1:0]        op;
    } ctl_state_t;

endpackage

// File: rtl/blkctl_decode.sv
module blkctl_decode
    import blkctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output reg_sel_e          sel,
    output logic              err
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic in_window;
    logic aligned;
    logic access_ok;

    generate
        if (HI_W > 0) begin : g_hi
            assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
        end else begin : g_nohi
            assign in_window = 1'b1;
        end
    endgenerate

    assign aligned = (addr[1:0] == 2'b00);
    assign sel     = reg_sel_e'(addr[WIN_BITS-1:2]);

    always_comb begin
        unique case (sel)
            SEL_OP:                        access_ok = write;
            SEL_STAT, SEL_SIZE, SEL_BSIZE: access_ok = !write;
            default:                       access_ok = 1'b1;
        endcase
    end

    assign err = !(in_window && aligned && access_ok);

endmodule

// File: rtl/blkctl_rsp.sv
module blkctl_rsp #(
    parameter int SRCID_W = 8,
    parameter int TRDID_W = 4,
    parameter int PKTID_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_err,
    input  logic [DATA_W-1:0]  in_rdata,
    input  logic               in_ack,
    input  logic [SRCID_W-1:0] in_srcid,
    input  logic [TRDID_W-1:0] in_trdid,
    input  logic [PKTID_W-1:0] in_pktid,
    output logic               out_valid,
    output logic               out_err,
    output logic [DATA_W-1:0]  out_rdata,
    output logic               out_ack,
    output logic [SRCID_W-1:0] out_srcid,
    output logic [TRDID_W-1:0] out_trdid,
    output logic [PKTID_W-1:0] out_pktid
);
    typedef struct packed {
        logic               valid;
        logic               err;
        logic [DATA_W-1:0]  rdata;
        logic               ack;
        logic [SRCID_W-1:0] srcid;
        logic [TRDID_W-1:0] trdid;
        logic [PKTID_W-1:0] pktid;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = in_valid;
        rsp_d.ack   = in_valid && in_ack;
        if (in_valid) begin
            rsp_d.err   = in_err;
            rsp_d.rdata = in_err ? '0 : in_rdata;
            rsp_d.srcid = in_srcid;
            rsp_d.trdid = in_trdid;
            rsp_d.pktid = in_pktid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign out_valid = rsp_q.valid;
    assign out_err   = rsp_q.err;
    assign out_rdata = rsp_q.rdata;
    assign out_ack   = rsp_q.ack;
    assign out_srcid = rsp_q.srcid;
    assign out_trdid = rsp_q.trdid;
    assign out_pktid = rsp_q.pktid;

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_ack);
    assert_rsp_echo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_srcid == $past(in_srcid)) && (out_pktid == $past(in_pktid)));

endmodule

// File: rtl/blkctl_target.sv
module blkctl_target
    import blkctl_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SRCID_W     = 8,
    parameter int          TRDID_W     = 4,
    parameter int          PKTID_W     = 4,
    parameter logic [31:0] DEV_BLOCKS  = 32'd65536,
    parameter logic [31:0] BLOCK_BYTES = 32'd512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [SRCID_W-1:0] req_srcid,
    input  logic [TRDID_W-1:0] req_trdid,
    input  logic [PKTID_W-1:0] req_pktid,
    output logic               rsp_valid,
    output logic               rsp_error,
    output logic [31:0]        rsp_rdata,
    output logic [SRCID_W-1:0] rsp_srcid,
    output logic [TRDID_W-1:0] rsp_trdid,
    output logic [PKTID_W-1:0] rsp_pktid,
    output logic               eng_start,
    output logic [1:0]         eng_op,
    input  logic [2:0]         eng_status,
    output logic               eng_ack,
    output logic [31:0]        cfg_buf_addr,
    output logic [31:0]        cfg_count,
    output logic [31:0]        cfg_lba,
    output logic               irq
);
    reg_sel_e   dec_sel;
    logic       dec_err;
    logic       eng_idle;
    logic       wr_ok;
    logic       rd_ok;
    logic       ack_d;
    logic [31:0] rdata_d;
    ctl_state_t st_d, st_q;

    blkctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (req_addr),
        .write (req_write),
        .sel   (dec_sel),
        .err   (dec_err)
    );

    assign eng_idle = (eng_status == ST_IDLE);
    assign wr_ok    = req_valid && req_write && !dec_err;
    assign rd_ok    = req_valid && !req_write && !dec_err;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_ok) begin
            unique case (dec_sel)
                SEL_BUF:   if (eng_idle) st_d.buf_addr = req_wdata;
                SEL_CNT:   if (eng_idle) st_d.count    = req_wdata;
                SEL_LBA:   if (eng_idle) st_d.lba      = req_wdata;
                SEL_OP: begin
                    if (eng_idle && (req_wdata == 32'(OP_READ) || req_wdata == 32'(OP_WRITE))) begin
                        st_d.start = 1'b1;
                        st_d.op    = req_wdata[1:0];
                    end
                end
                SEL_IRQEN: st_d.irq_en = |req_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (dec_sel)
            SEL_BUF:   rdata_d = st_q.buf_addr;
            SEL_CNT:   rdata_d = st_q.count;
            SEL_LBA:   rdata_d = st_q.lba;
            SEL_STAT:  rdata_d = {29'd0, eng_status};
            SEL_IRQEN: rdata_d = {31'd0, st_q.irq_en};
            SEL_SIZE:  rdata_d = DEV_BLOCKS;
            SEL_BSIZE: rdata_d = BLOCK_BYTES;
            default:   rdata_d = '0;
        endcase
    end

    assign ack_d = rd_ok && (dec_sel == SEL_STAT) && is_terminal(eng_status);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.irq_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    blkctl_rsp #(
        .SRCID_W (SRCID_W),
        .TRDID_W (TRDID_W),
        .PKTID_W (PKTID_W),
        .DATA_W  (32)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_err    (dec_err),
        .in_rdata  (rdata_d),
        .in_ack    (ack_d),
        .in_srcid  (req_srcid),
        .in_trdid  (req_trdid),
        .in_pktid  (req_pktid),
        .out_valid (rsp_valid),
        .out_err   (rsp_error),
        .out_rdata (rsp_rdata),
        .out_ack   (eng_ack),
        .out_srcid (rsp_srcid),
        .out_trdid (rsp_trdid),
        .out_pktid (rsp_pktid)
    );

    assign eng_start    = st_q.start;
    assign eng_op       = st_q.op;
    assign cfg_buf_addr = st_q.buf_addr;
    assign cfg_count    = st_q.count;
    assign cfg_lba      = st_q.lba;
    assign irq          = st_q.irq_en && is_terminal(eng_status);

    assert_err_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_err) |=> $stable(cfg_buf_addr) && $stable(cfg_count)
                                   && $stable(cfg_lba) && !eng_start);
    assert_start_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> ($past(eng_status) == ST_IDLE) && $past(req_valid));
    assert_locked_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_status != ST_IDLE) |=> $stable(cfg_buf_addr) && $stable(cfg_count)
                                   && $stable(cfg_lba) && !eng_start);
    assert_ack_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ack |-> is_terminal($past(eng_status)) && rsp_valid && !rsp_error);
    assert_no_irq_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_status == ST_BUSY) |-> !irq);
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

endmodule

// File: tb/blkctl_target_bench.sv
module blkctl_target_bench;
    localparam logic [31:0] DEV_BLOCKS  = 32'd65536;
    localparam logic [31:0] BLOCK_BYTES = 32'd512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_srcid = '0;
    logic [3:0]  req_trdid = '0;
    logic [3:0]  req_pktid = '0;
    logic        rsp_valid, rsp_error, eng_start, eng_ack, irq;
    logic [31:0] rsp_rdata, cfg_buf_addr, cfg_count, cfg_lba;
    logic [7:0]  rsp_srcid;
    logic [3:0]  rsp_trdid, rsp_pktid;
    logic [1:0]  eng_op;
    logic [2:0]  eng_status = 3'd0;

    int n_checks = 0;
    int n_fail   = 0;
    int seq      = 0;

    logic [31:0] m_buf = '0, m_cnt = '0, m_lba = '0;
    logic        m_ien = 1'b1;

    logic        c_valid, c_err, c_start, c_ack;
    logic [31:0] c_rdata;
    logic [1:0]  c_op;

    always #10 clk = ~clk;

    blkctl_target #(
        .ADDR_W(8), .SRCID_W(8), .TRDID_W(4), .PKTID_W(4),
        .DEV_BLOCKS(DEV_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)
    ) u_blkctl_target (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_srcid(req_srcid), .req_trdid(req_trdid),
        .req_pktid(req_pktid),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .rsp_srcid(rsp_srcid), .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid),
        .eng_start(eng_start), .eng_op(eng_op), .eng_status(eng_status),
        .eng_ack(eng_ack),
        .cfg_buf_addr(cfg_buf_addr), .cfg_count(cfg_count), .cfg_lba(cfg_lba),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_err(input logic w, input logic [7:0] a);
        if (a >= 8'h20 || a[1:0] != 2'b00) return 1'b1;
        if (!w && a == 8'h0C) return 1'b1;
        if (w && (a == 8'h10 || a == 8'h18 || a == 8'h1C)) return 1'b1;
        return 1'b0;
    endfunction

    // One bus access; results captured in the response cycle, away from the edge.
    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [7:0] s;
        logic [3:0] t, p;
        s = 8'(seq * 37 + 5);
        t = 4'(seq);
        p = 4'(seq * 3 + 1);
        seq++;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        req_srcid = s; req_trdid = t; req_pktid = p;
        @(negedge clk);
        req_valid = 1'b0;
        c_valid = rsp_valid; c_err = rsp_error; c_rdata = rsp_rdata;
        c_start = eng_start; c_op = eng_op; c_ack = eng_ack;
        check("R11 rsp_valid", 32'(c_valid), 32'd1);
        check("R11 echo ids", {12'd0, rsp_srcid, rsp_trdid, rsp_pktid}, {12'd0, s, t, p});
        @(negedge clk);
        check("R11 single response", 32'(rsp_valid), 32'd0);
    endtask

    task automatic check_params(input string tag);
        access(1'b0, 8'h00, '0); check({tag, " buf"}, c_rdata, m_buf);
        access(1'b0, 8'h04, '0); check({tag, " cnt"}, c_rdata, m_cnt);
        access(1'b0, 8'h08, '0); check({tag, " lba"}, c_rdata, m_lba);
        access(1'b0, 8'h14, '0); check({tag, " irq_en"}, c_rdata, 32'(m_ien));
        check("R12 cfg_buf_addr", cfg_buf_addr, m_buf);
        check("R12 cfg_count", cfg_count, m_cnt);
        check("R12 cfg_lba", cfg_lba, m_lba);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] pats [5];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h8000_0001; pats[4] = 32'h1234_5678;

        // R1 reset state
        eng_status = 3'd2;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 eng_start", 32'(eng_start), 32'd0);
        check("R1 eng_ack", 32'(eng_ack), 32'd0);
        check("R1 cfg zero", cfg_buf_addr | cfg_count | cfg_lba, 32'd0);
        check("R1 irq enabled at reset", 32'(irq), 32'd1);
        rst_n = 1'b1;
        eng_status = 3'd0;
        check_params("R1");

        // R2 / R12 parameter storage with several patterns
        for (int i = 0; i < 5; i++) begin
            m_buf = pats[i]; m_cnt = pats[(i+1)%5] ^ 32'h0F0F_0000; m_lba = ~pats[i];
            access(1'b1, 8'h00, m_buf); check("R2 wr buf err", 32'(c_err), 32'd0);
            access(1'b1, 8'h04, m_cnt);
            access(1'b1, 8'h08, m_lba);
            check_params("R2");
        end
        for (int b = 0; b < 32; b += 7) begin
            m_lba = 32'd1 << b;
            access(1'b1, 8'h08, m_lba);
            access(1'b0, 8'h08, '0); check("R2 walking lba", c_rdata, m_lba);
        end

        // R9 constant registers
        access(1'b0, 8'h18, '0); check("R9 dev size", c_rdata, DEV_BLOCKS);
        access(1'b0, 8'h1C, '0); check("R9 block size", c_rdata, BLOCK_BYTES);

        // R4 opcode values while idle
        for (int v = 0; v < 5; v++) begin
            logic [31:0] d;
            d = (v == 4) ? 32'h0000_0101 : 32'(v);
            access(1'b1, 8'h0C, d);
            check("R4 op err", 32'(c_err), 32'd0);
            check("R4 start", 32'(c_start), (d == 32'd1 || d == 32'd2) ? 32'd1 : 32'd0);
            if (d == 32'd1 || d == 32'd2) check("R4 eng_op", 32'(c_op), d);
            check("R4 start one cycle", 32'(eng_start), 32'd0);
        end

        // R3 writes locked out while not idle
        for (int s = 1; s < 8; s++) begin
            eng_status = 3'(s);
            access(1'b1, 8'h00, 32'hDEAD_0000 + 32'(s)); check("R3 buf write ok rsp", 32'(c_err), 32'd0);
            access(1'b1, 8'h04, 32'hBEEF_0000 + 32'(s));
            access(1'b1, 8'h08, 32'hCAFE_0000 + 32'(s));
            access(1'b1, 8'h0C, 32'd1); check("R3 no start", 32'(c_start), 32'd0);
            access(1'b1, 8'h0C, 32'd2); check("R3 no start wr", 32'(c_start), 32'd0);
            check("R3 cfg_buf held", cfg_buf_addr, m_buf);
            check("R3 cfg_count held", cfg_count, m_cnt);
            check("R3 cfg_lba held", cfg_lba, m_lba);
        end
        eng_status = 3'd0;
        check_params("R3");

        // R5 / R6 status read, every code
        for (int s = 0; s < 8; s++) begin
            eng_status = 3'(s);
            access(1'b0, 8'h10, '0);
            check("R5 status value", c_rdata, 32'(s));
            check("R6 ack", 32'(c_ack), (s >= 2 && s <= 5) ? 32'd1 : 32'd0);
            check("R6 ack one cycle", 32'(eng_ack), 32'd0);
            access(1'b0, 8'h14, '0);
            check("R6 no ack other reg", 32'(c_ack), 32'd0);
        end

        // R7 / R8 interrupt against every code and both enables, written in any state
        for (int e = 0; e < 4; e++) begin
            logic [31:0] d;
            d = (e == 0) ? 32'd0 : (e == 1) ? 32'd1 : (e == 2) ? 32'd0 : 32'h8000_0000;
            eng_status = 3'(e + 1);
            access(1'b1, 8'h14, d);
            m_ien = (d != 0);
            access(1'b0, 8'h14, '0); check("R8 irq_en readback", c_rdata, 32'(m_ien));
            for (int s = 0; s < 8; s++) begin
                @(negedge clk); eng_status = 3'(s); #1;
                check("R7 irq", 32'(irq), (m_ien && s >= 2 && s <= 5) ? 32'd1 : 32'd0);
            end
        end
        eng_status = 3'd0;

        // R10 exhaustive read sweep with idle engine
        for (int a = 0; a < 256; a++) begin
            logic [31:0] e;
            access(1'b0, 8'(a), '0);
            check("R10 read err", 32'(c_err), 32'(exp_err(1'b0, 8'(a))));
            case (a)
                8'h00: e = m_buf;  8'h04: e = m_cnt;  8'h08: e = m_lba;
                8'h10: e = 32'd0;  8'h14: e = 32'(m_ien);
                8'h18: e = DEV_BLOCKS; 8'h1C: e = BLOCK_BYTES;
                default: e = 32'd0;
            endcase
            check("R10 read data", c_rdata, e);
        end

        // R10 sweep of every illegal write
        for (int a = 0; a < 256; a++) begin
            if (exp_err(1'b1, 8'(a))) begin
                access(1'b1, 8'(a), 32'hFFFF_FFFF);
                check("R10 write err", 32'(c_err), 32'd1);
                check("R10 write rdata", c_rdata, 32'd0);
                check("R10 no start", 32'(c_start), 32'd0);
            end
        end
        check_params("R10");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule